// File: doc/BRIEF.md
# Latched Serial-to-Parallel Output Register

This block turns a serial bit stream into a parallel word and keeps the visible word steady while the next one arrives. Each rising clock edge with the shift enable high moves the bits in an internal staging chain one place along. The serial input enters the first stage, and the bit in the last stage drops out of the chain. The parallel outputs are driven only by a separate holding bank. That bank takes a copy of the whole staging chain in one clock, and only when the load strobe is high.

The last staging stage is also brought out as a cascade output. Several of these blocks can therefore be strung one after another, each passing its overflow bit to the serial input of the next. A synchronous clear empties both the staging chain and the holding bank. The width is a parameter, 8 by default, and must be at least 2.

Top module: `sipo_hold_reg`

## Requirements
- R1: A clock edge with `clr` high sets every staging stage and every bit of `par_q` to 0, so `par_q` and `casc_out` both read 0 after that edge.
- R2: A clock edge with `shift_en` high and `clr` low loads staging stage 0 from `ser_in` and loads stage i from stage i-1.
- R3: A bit presented on `ser_in` during the first of WIDTH consecutive shift edges appears on `casc_out` right after the WIDTH-th of those edges.
- R4: A clock edge with `shift_en` low and `clr` low leaves the staging chain unchanged. This is seen on `casc_out` and through later loads.
- R5: `par_q` does not change on any edge where `load_stb` and `clr` are both low, however many shifts take place.
- R6: A clock edge with `load_stb` high and `clr` low copies the staging chain into `par_q` in that single edge, with stage i going to `par_q[i]`.
- R7: When `load_stb` and `shift_en` are both high on the same edge, `par_q` receives the staging contents from before that edge's shift.
- R8: `casc_out` always equals the last staging stage, WIDTH-1. This is the stage that `ser_in` reaches after WIDTH shifts.
- R9: `clr` takes priority over `shift_en` and `load_stb` on the same edge.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Rising-edge clock |
| clr | input | 1 | Synchronous clear of staging chain and holding bank |
| ser_in | input | 1 | Serial data into staging stage 0 |
| shift_en | input | 1 | Advance the staging chain on this edge |
| load_stb | input | 1 | Copy the staging chain into the holding bank on this edge |
| par_q | output | WIDTH | Parallel word from the holding bank |
| casc_out | output | 1 | Last staging stage, for chaining to a following block |

## Verification
Every result is due exactly one rising edge after the cycle that requests it. A shift shows on `casc_out`, a load or clear shows on `par_q`, and a bit needs WIDTH shift edges to travel from `ser_in` to `casc_out`. The bench drives inputs on the falling edge and updates its queue-based model for the coming rising edge. It then compares both outputs on the next falling edge, after the one register stage has settled. The checks on simultaneous shift and load, and on a clear combined with both, test the ordering rules at the exact edge where they apply.

// File: rtl/sipo_pkg.sv
package sipo_pkg;

   // Operation chosen for the holding bank on a given edge
   typedef enum logic [1:0] {
      BANK_KEEP    = 2'd0,
      BANK_CAPTURE = 2'd1,
      BANK_ZERO    = 2'd2
   } bank_op_e;

   // Clear dominates capture, capture dominates keep
   function automatic bank_op_e pick_bank_op(input logic clr_i, input logic load_i);
      if (clr_i)       return BANK_ZERO;
      else if (load_i) return BANK_CAPTURE;
      else             return BANK_KEEP;
   endfunction

endpackage

// File: rtl/sipo_stage_chain.sv
module sipo_stage_chain #(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             ser_in,
   input  logic             shift_en,
   output logic [WIDTH-1:0] stage_q
);
   localparam int LAST = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_check
      $error("sipo_stage_chain: WIDTH must be at least 2");
   end

   // One flop per stage; stage 0 is fed from the serial input
   for (genvar i = 0; i < WIDTH; i++) begin : g_stage
      logic next_bit;
      if (i == 0) begin : g_head
         assign next_bit = ser_in;
      end else begin : g_body
         assign next_bit = stage_q[i-1];
      end
      always_ff @(posedge clk) begin
         if (clr)           stage_q[i] <= 1'b0;
         else if (shift_en) stage_q[i] <= next_bit;
      end
   end

   // R2: head stage takes the serial input, others take their neighbour
   p_shift_head_r2: assert property (@(posedge clk) disable iff (clr)
      shift_en |=> stage_q[0] == $past(ser_in));
   p_shift_body_r2: assert property (@(posedge clk) disable iff (clr)
      shift_en |=> stage_q[LAST:1] == $past(stage_q[LAST-1:0]));
   // R4: no enable, no movement
   p_idle_hold_r4: assert property (@(posedge clk) disable iff (clr)
      !shift_en |=> $stable(stage_q));
   // R1: clear empties the chain
   p_clear_chain_r1: assert property (@(posedge clk)
      clr |=> stage_q == '0);

endmodule

// File: rtl/sipo_hold_bank.sv
module sipo_hold_bank
   import sipo_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  bank_op_e         op,
   input  logic [WIDTH-1:0] d,
   output logic [WIDTH-1:0] q
);
   if (WIDTH < 1) begin : g_width_check
      $error("sipo_hold_bank: WIDTH must be positive");
   end

   always_ff @(posedge clk) begin
      unique case (op)
         BANK_ZERO:    q <= '0;
         BANK_CAPTURE: q <= d;
         default:      q <= q;
      endcase
   end

   // R5: outputs frozen unless captured or cleared
   p_frozen_r5: assert property (@(posedge clk) disable iff (op == BANK_ZERO)
      op == BANK_KEEP |=> $stable(q));
   // R6: a capture copies the whole input word in one edge
   p_capture_r6: assert property (@(posedge clk) disable iff (op == BANK_ZERO)
      op == BANK_CAPTURE |=> q == $past(d));

endmodule

// File: rtl/sipo_hold_reg.sv
module sipo_hold_reg
   import sipo_pkg::*;
#(
   parameter int WIDTH = 8
) (
   input  logic             clk,
   input  logic             clr,
   input  logic             ser_in,
   input  logic             shift_en,
   input  logic             load_stb,
   output logic [WIDTH-1:0] par_q,
   output logic             casc_out
);
   localparam int LAST = WIDTH - 1;

   if (WIDTH < 2) begin : g_width_check
      $error("sipo_hold_reg: WIDTH must be at least 2");
   end

   logic [WIDTH-1:0] chain_q;
   bank_op_e         bank_op;

   sipo_stage_chain #(.WIDTH(WIDTH)) u_chain (
      .clk      (clk),
      .clr      (clr),
      .ser_in   (ser_in),
      .shift_en (shift_en),
      .stage_q  (chain_q)
   );

   assign bank_op = pick_bank_op(clr, load_stb);

   sipo_hold_bank #(.WIDTH(WIDTH)) u_bank (
      .clk (clk),
      .op  (bank_op),
      .d   (chain_q),
      .q   (par_q)
   );

   assign casc_out = chain_q[LAST];

   // R7: simultaneous shift and load latch the pre-shift word
   p_load_before_shift_r7: assert property (@(posedge clk) disable iff (clr)
      (load_stb && shift_en) |=> par_q == {$past(casc_out), $past(chain_q[LAST-1:0])});
   // R8: cascade follows the stage just before it after a shift
   p_cascade_r8: assert property (@(posedge clk) disable iff (clr)
      shift_en |=> casc_out == $past(chain_q[LAST-1]));
   // R9: clear wins over shift and load
   p_clear_wins_r9: assert property (@(posedge clk)
      clr |=> (par_q == '0 && !casc_out));

endmodule

// File: tb/sipo_hold_reg_bench.sv
module sipo_hold_reg_bench;
   localparam int  W          = 8;
   localparam time CLK_PERIOD = 10;
   localparam int  WATCHDOG   = 200000;

   logic         clk = 1'b0;
   logic         clr = 1'b1;
   logic         ser_in = 1'b0;
   logic         shift_en = 1'b0;
   logic         load_stb = 1'b0;
   logic [W-1:0] par_q;
   logic         casc_out;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   bit           mq[$];
   logic [W-1:0] m_out;
   string        tag_out;
   string        tag_casc;

   always #(CLK_PERIOD/2) clk = ~clk;

   sipo_hold_reg #(.WIDTH(W)) u_sipo_hold_reg (
      .clk(clk), .clr(clr), .ser_in(ser_in), .shift_en(shift_en),
      .load_stb(load_stb), .par_q(par_q), .casc_out(casc_out)
   );

   task automatic check(input string tag, input logic [W-1:0] act, input logic [W-1:0] exp);
      checks++;
      if (act !== exp) begin
         errors++;
         $display("FAIL %s: actual=%h expected=%h at %0t", tag, act, exp, $time);
      end
   endtask

   // Drive at a falling edge, advance the model, compare at the next falling edge
   task automatic step(input logic c, input logic s, input logic sh, input logic ld);
      clr = c; ser_in = s; shift_en = sh; load_stb = ld;
      if (c) begin
         mq = {};
         for (int i = 0; i < W; i++) mq.push_back(1'b0);
         m_out    = '0;
         tag_out  = (sh || ld) ? "R9 clear over load" : "R1 clear output";
         tag_casc = (sh || ld) ? "R9 clear over shift" : "R1 clear chain";
      end else begin
         if (ld) begin
            for (int i = 0; i < W; i++) m_out[i] = mq[i];
            tag_out = sh ? "R7 load with shift" : "R6 load copy";
         end else begin
            tag_out = "R5 output held";
         end
         if (sh) begin
            mq.push_front(s);
            void'(mq.pop_back());
            tag_casc = "R2/R8 cascade after shift";
         end else begin
            tag_casc = "R4/R8 cascade idle";
         end
      end
      @(posedge clk);
      @(negedge clk);
      check(tag_out, par_q, m_out);
      check(tag_casc, {{(W-1){1'b0}}, casc_out}, {{(W-1){1'b0}}, mq[W-1]});
   endtask

   task automatic shift_word(input logic [W-1:0] word);
      for (int i = W-1; i >= 0; i--) step(1'b0, word[i], 1'b1, 1'b0);
   endtask

   initial begin
      @(negedge clk);
      // R1: reset state
      step(1'b1, 1'b0, 1'b0, 1'b0);
      step(1'b1, 1'b0, 1'b0, 1'b0);
      check("R1 reset par_q", par_q, '0);

      // R3: single one travels to the cascade in W shifts
      step(1'b0, 1'b1, 1'b1, 1'b0);
      for (int i = 1; i < W; i++) step(1'b0, 1'b0, 1'b1, 1'b0);
      check("R3 arrival after W shifts", {{(W-1){1'b0}}, casc_out}, {{(W-1){1'b0}}, 1'b1});
      step(1'b0, 1'b0, 1'b1, 1'b0);
      check("R3 leaves after W+1 shifts", {{(W-1){1'b0}}, casc_out}, '0);

      // R5 then R6: shift a word without loading, then load it
      shift_word(8'hA5);
      step(1'b0, 1'b0, 1'b0, 1'b1);
      check("R6 loaded pattern A5", par_q, 8'hA5);
      shift_word(8'h3C);
      check("R5 still A5 after shifting", par_q, 8'hA5);

      // R4: serial input toggles with shift disabled
      for (int i = 0; i < 6; i++) step(1'b0, i[0], 1'b0, 1'b0);
      step(1'b0, 1'b1, 1'b0, 1'b1);
      check("R4 chain kept 3C", par_q, 8'h3C);

      // R7: load together with shift
      for (int i = 0; i < 2*W; i++) step(1'b0, i[1], 1'b1, i % 3 == 0);

      // R9: clear with both controls high
      step(1'b0, 1'b1, 1'b1, 1'b1);
      step(1'b1, 1'b1, 1'b1, 1'b1);
      check("R9 clear dominates", par_q, '0);

      // Mixed traffic
      for (int i = 0; i < 300; i++) begin
         logic [3:0] r;
         r = 4'($urandom);
         step(($urandom % 53) == 0, r[0], r[1] | r[2], r[3] & r[2]);
      end

      done = 1'b1;
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
   end

   initial begin
      repeat (WATCHDOG) @(posedge clk);
      if (!done) begin
         checks++;
         errors++;
         $display("FAIL watchdog: actual=running expected=finished");
         $display("Result: errors=%0d of %0d checks", errors, checks);
         $finish;
      end
   end

endmodule